// File: doc/BRIEF.md
# Interlocked Handshake Memory Read Requester

This block is the requesting side of a shared memory bus that has no common transfer clock. A user issues a read command with an address. The block first raises a bus request and waits for a grant. It then drives the address and a read-request line together. The memory answers through separate data-ready and acknowledge lines. Every edge of the exchange waits for the edge before it, so a responder with any latency is served correctly.

The block runs on its own clock. The grant, the memory's acknowledge and the data-ready line arrive with no known timing relation to that clock, so each one passes through a two-stage synchronizer before the state machine uses it. The phase order is fixed. Read-request rises and the memory acknowledges it. Read-request falls and the memory's acknowledge falls. Data-ready rises and the block raises its own acknowledge. Data-ready falls and the block drops its acknowledge. The returned word is captured when the block raises its acknowledge. A one-cycle done pulse is given when that acknowledge falls, and in the same cycle the block releases the bus.

Top module: `hsk_read_master`

## Requirements
- R1: After reset, bus_req, rd_req, ack_out, bus_addr_oe and rsp_done are 0, and cmd_ready is 1.
- R2: A command accepted while cmd_ready is 1 raises bus_req. rd_req rises only after bus_gnt has been seen high.
- R3: Whenever rd_req is 1, bus_req and bus_addr_oe are also 1 and bus_addr carries the commanded address. When bus_addr_oe is 0, bus_addr is all zeros.
- R4: rd_req stays high until ack_in has been seen high, and it then falls.
- R5: ack_out rises only after data_rdy has been seen high, following the read-request phase, and it falls only after data_rdy has been seen low.
- R6: rsp_data holds the bus_data value present when ack_out rises. It keeps that value after the memory changes the data lines, and until the next read completes.
- R7: rsp_done is a one-cycle pulse that occurs in the cycle ack_out falls. In that same cycle bus_req and bus_addr_oe are 0.
- R8: rd_req and ack_out are never high at the same time.
- R9: A read completes with the stored word for any responder and arbiter delay, including zero delay and delays of many clock periods.
- R10: While a read is in progress, cmd_ready is 0 and cmd_valid is ignored. A command offered then neither changes the returned word nor starts a further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Requester clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Read command strobe |
| cmd_addr | input | AW | Address of the word to read |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| rsp_data | output | DW | Word returned by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter (asynchronous) |
| bus_addr | output | AW | Shared address lines (zero when released) |
| bus_addr_oe | output | 1 | Address driver enable |
| bus_data | input | DW | Shared data lines driven by the memory |
| rd_req | output | 1 | Read-request handshake line |
| data_rdy | input | 1 | Memory data-ready line (asynchronous) |
| ack_in | input | 1 | Memory acknowledge of the read request (asynchronous) |
| ack_out | output | 1 | Requester acknowledge of data-ready |

## Verification
Reads are issued with random addresses while the arbiter and memory insert random delays up to a programmable maximum. This shows that the returned word depends on the handshake order and not on the elapsed time. Directed runs with zero delay exercise edges that arrive back to back through the synchronizers. Directed runs with delays of many clock periods show that each phase waits as long as needed. After it drops data-ready, the memory puts a garbage value on the data lines, which separates a word captured at the acknowledge from one read later. A command offered in the middle of a read tells a block that ignores it apart from one that restarts or starts a second transfer.

// File: rtl/hsk_read_master.sv
`timescale 1ns/1ps
module hsk_read_master #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  input  logic [DW-1:0] bus_data,
  output logic          rd_req,
  input  logic          data_rdy,
  input  logic          ack_in,
  output logic          ack_out
);

  typedef enum logic [2:0] {
    S_IDLE, S_ARB, S_REQ, S_REL, S_WAIT, S_DACK
  } st_t;

  st_t           st;
  logic [1:0]    gnt_q, ack_q, rdy_q;
  logic          gnt_s, ack_s, rdy_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ack_q <= '0;
      rdy_q <= '0;
    end else begin
      gnt_q <= {gnt_q[0], bus_gnt};
      ack_q <= {ack_q[0], ack_in};
      rdy_q <= {rdy_q[0], data_rdy};
    end
  end

  assign gnt_s = gnt_q[1];
  assign ack_s = ack_q[1];
  assign rdy_s = rdy_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          st     <= S_ARB;
        end
        S_ARB:  if (gnt_s)  st <= S_REQ;
        S_REQ:  if (ack_s)  st <= S_REL;
        S_REL:  if (!ack_s) st <= S_WAIT;
        S_WAIT: if (rdy_s) begin
          data_q <= bus_data;
          st     <= S_DACK;
        end
        S_DACK: if (!rdy_s) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (st == S_IDLE);
  assign bus_req     = (st != S_IDLE);
  assign bus_addr_oe = (st != S_IDLE) && (st != S_ARB);
  assign bus_addr    = bus_addr_oe ? addr_q : '0;
  assign rd_req      = (st == S_REQ);
  assign ack_out     = (st == S_DACK);
  assign rsp_data    = data_q;
  assign rsp_done    = done_q;

  // R2
  rdreq_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(gnt_s));

  // R3
  addr_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (bus_req && bus_addr_oe));

  // R4
  rdreq_drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_req) |-> $past(ack_s));

  // R5
  ack_rise_on_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(rdy_s));

  // R5
  ack_fall_on_rdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> !$past(rdy_s));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(ack_out)) |-> $stable(rsp_data));

  // R7
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($fell(ack_out) && !bus_req && !bus_addr_oe));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && ack_out));

endmodule

// File: tb/sim_hsk_read_master.sv
`timescale 1ns/1ps
module sim_hsk_read_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_ready;
  logic [DW-1:0] rsp_data;
  logic          rsp_done;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_addr_oe;
  logic [DW-1:0] bus_data = '0;
  logic          rd_req;
  logic          data_rdy = 1'b0;
  logic          ack_in = 1'b0;
  logic          ack_out;

  int n_chk = 0;
  int n_bad = 0;
  int max_dly = 0;
  logic [AW-1:0] cur_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_read_master #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .rsp_data(rsp_data), .rsp_done(rsp_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_addr_oe(bus_addr_oe), .bus_data(bus_data), .rd_req(rd_req),
    .data_rdy(data_rdy), .ack_in(ack_in), .ack_out(ack_out)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a ^ 8'hA5, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pause();
    int d;
    d = $urandom_range(max_dly);
    #(d);
  endtask

  // arbiter
  initial forever begin
    wait (bus_req == 1'b1);
    pause();
    bus_gnt = 1'b1;
    wait (bus_req == 1'b0);
    bus_gnt = 1'b0;
  end

  // memory responder
  initial forever begin
    wait (rd_req == 1'b1);
    check(bus_addr_oe && bus_req && bus_addr == cur_addr, "R3 addr",
          {bus_addr_oe, bus_req, bus_addr}, {2'b11, cur_addr});
    check(bus_gnt == 1'b1, "R2 grant before rd_req", bus_gnt, 1);
    pause();
    ack_in = 1'b1;
    wait (rd_req == 1'b0);
    pause();
    ack_in = 1'b0;
    pause();
    bus_data = word_of(bus_addr);
    pause();
    data_rdy = 1'b1;
    wait (ack_out == 1'b1);
    pause();
    data_rdy = 1'b0;
    bus_data = 16'hDEAD;
    wait (ack_out == 1'b0);
  end

  task automatic do_read(input logic [AW-1:0] a, input bit poke);
    int cyc;
    bit got;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10 ready when idle", cmd_ready, 1);
    cur_addr  = a;
    cmd_addr  = a;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_req == 1'b1, "R2 bus_req raised", bus_req, 1);
    got = 0;
    for (cyc = 0; cyc < 5000 && !got; cyc++) begin
      if (poke && cyc == 2 && !rsp_done) begin
        check(cmd_ready == 1'b0, "R10 busy", cmd_ready, 0);
        cmd_addr  = a ^ 8'hFF;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
      if (rsp_done) got = 1;
    end
    check(got, "R9 completion", got, 1);
    if (got) begin
      check(rsp_data == word_of(a), "R6/R9 data", rsp_data, word_of(a));
      check(!ack_out && !bus_req && !bus_addr_oe && bus_addr == '0, "R7 release",
            {ack_out, bus_req, bus_addr_oe, bus_addr}, 0);
      @(negedge clk);
      check(rsp_done == 1'b0, "R7 single pulse", rsp_done, 0);
      if (poke) begin
        repeat (4) @(negedge clk);
        check(bus_req == 1'b0 && rsp_data == word_of(a), "R10 ignored",
              {bus_req, rsp_data}, {1'b0, word_of(a)});
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req && !rd_req && !ack_out && !bus_addr_oe && !rsp_done && cmd_ready,
          "R1 reset state", {bus_req, rd_req, ack_out, bus_addr_oe, rsp_done, cmd_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 zero-delay responder
    max_dly = 0;
    do_read(8'h00, 0);
    do_read(8'hFF, 0);
    // R9 long-delay responder
    max_dly = 20 * CLK_PERIOD;
    do_read(8'h5A, 0);
    // R10 command during transfer
    max_dly = 5 * CLK_PERIOD;
    do_read(8'h3C, 1);
    // R6 random reads, R9 random latency
    for (int i = 0; i < 40; i++) begin
      max_dly = $urandom_range(8 * CLK_PERIOD);
      do_read(AW'($urandom), (i % 7) == 3);
    end
    // R6 word held through idle time
    repeat (10) @(negedge clk);
    check(rsp_data == word_of(cur_addr), "R6 hold", rsp_data, word_of(cur_addr));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule